// File: doc/BRIEF.md
# Addressed register-file target on a two-wire serial bus

This block is a target (slave) device on a two-wire serial bus of the I2C kind. It has a fixed 7-bit device address, set by a parameter, and a small bank of byte registers. It watches the clock line and the data line through synchronizers and runs them on its own system clock. It recognises bus framing conditions and takes part only in transactions that carry its own address. It drives the data line through an open-drain style output: when the output is asserted, the line is pulled low; otherwise the line is released.

A write transaction starts with the device address and a direction bit of 0. The byte after that sets an internal register pointer. Every further byte is stored at the pointer, and the pointer then advances. A read transaction uses a direction bit of 1 and returns register contents starting at the current pointer. This is most often done through a repeated START right after a pointer-setting write. Several copies with different addresses can share one bus. A copy that is not addressed never drives the line.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset the data-line pull output is deasserted and every register holds 0x00.
- R2: A falling data line while the clock line is high is a START, and a rising data line while the clock line is high is a STOP. Either one, at any point (even mid-byte), abandons the byte in progress and releases the data line. A START always begins a fresh address reception. A byte cut short this way is not stored.
- R3: After START the block samples 8 bits on clock-line rising edges, MSB first: the 7 address bits, then the direction bit (0 = write, 1 = read). If the 7 bits equal DEV_ADDR, the block pulls the data line low during the ninth clock pulse (ACK).
- R4: If the address bits differ from DEV_ADDR, the block keeps the data line released for the acknowledge slot and for every later clock pulse until the next START. Data bytes sent in such a transaction change no register.
- R5: In a write, the first byte after the address loads the register pointer from its low log2(NUM_REGS) bits. Every later byte is written to the register at the pointer and acknowledged with a low data line on its ninth pulse.
- R6: The pointer increases by one after each stored byte and wraps from NUM_REGS-1 to 0. The pointer is kept across transactions.
- R7: In a read, the block drives the register at the pointer MSB first, one bit per clock pulse. The pointer increases by one (with wrap) after each byte sent. When the master pulls the line low in the ninth pulse (ACK), the block sends the next byte.
- R8: When the master leaves the line high in the ninth pulse of a read (NACK), the block releases the data line and ignores further clock pulses until START or STOP. The pointer still advances past the byte that was NACKed.
- R9: The block changes its data-line pull output only after a falling edge of the clock line, or on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen on the pad |
| sda_in | input | 1 | Bus data line as seen on the pad (wired-AND of all drivers) |
| sda_pull_low | output | 1 | When 1 the pad pulls the data line low; when 0 the line is released |

## Verification
The main function is tried with several input patterns. An address sweep over all 128 values, with two instances on the bus, separates a correct address match from over-matching or under-matching. A nine-byte burst write from a pointer byte that has its high bits set tests whether the pointer truncates and wraps. Reads are done both through a repeated START and from the pointer left by an earlier transaction; these show whether the pointer is kept between transactions and advances on reads. Further patterns cover a NACK followed by extra clock pulses, a STOP in the middle of a byte, and a START in the middle of an address. They show that an aborted byte is discarded and that a released line stays silent.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK,
      ST_WAIT
   } rf_state_t;

endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   logic [STAGES-1:0] chain;

   initial begin : chk_params
      assert (STAGES >= 2) else $error("i2c_rf_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/i2c_rf_events.sv
module i2c_rf_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rf_store.sv
module i2c_rf_store #(
   parameter int NUM_REGS = 8,
   parameter int WIDTH    = 8,
   localparam int AW      = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] regs [NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      end else if (wr_en) begin
         regs[waddr] <= wdata;
      end
   end

   assign rdata = regs[raddr];

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> regs[$past(waddr)] == $past(wdata)); // R5

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
   import i2c_rf_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h2A,
   parameter int         NUM_REGS    = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_pull_low
);

   localparam int PTR_W   = $clog2(NUM_REGS);
   localparam int CNT_W   = $clog2(BYTE_W + 1);
   localparam int N_LINES = 2;

   initial begin : chk_params
      assert (NUM_REGS >= 2 && (NUM_REGS & (NUM_REGS - 1)) == 0)
         else $error("i2c_regfile_slave: NUM_REGS must be a power of two");
      assert (PTR_W <= BYTE_W)
         else $error("i2c_regfile_slave: pointer wider than a byte");
   end

   // line synchronizers, index 1 = clock line, index 0 = data line
   logic [N_LINES-1:0] line_raw;
   logic [N_LINES-1:0] line_s;
   assign line_raw = {scl_in, sda_in};

   for (genvar g = 0; g < N_LINES; g++) begin : g_sync
      i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (line_raw[g]),
         .dout (line_s[g])
      );
   end

   logic scl_rise, scl_fall, start_det, stop_det;

   i2c_rf_events u_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (line_s[1]),
      .sda_s    (line_s[0]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   logic               sda_s;
   assign sda_s = line_s[0];

   rf_state_t          state;
   logic [BYTE_W-1:0]  rx_sh;
   logic [BYTE_W-1:0]  tx_sh;
   logic [CNT_W-1:0]   bit_cnt;
   logic [PTR_W-1:0]   ptr;
   logic               ptr_pending;
   logic               is_read;
   logic               master_ack;
   logic               drive;
   logic [BYTE_W-1:0]  rd_data;
   logic               byte_end;
   logic               wr_en;

   assign byte_end = scl_fall && (bit_cnt == CNT_W'(BYTE_W));
   assign wr_en    = !start_det && !stop_det && (state == ST_RX) && byte_end && !ptr_pending;

   i2c_rf_store #(.NUM_REGS(NUM_REGS), .WIDTH(BYTE_W)) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(wr_en),
      .waddr(ptr),
      .wdata(rx_sh),
      .raddr(ptr),
      .rdata(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         rx_sh       <= '0;
         tx_sh       <= '0;
         bit_cnt     <= '0;
         ptr         <= '0;
         ptr_pending <= 1'b0;
         is_read     <= 1'b0;
         master_ack  <= 1'b0;
         drive       <= 1'b0;
      end else if (start_det) begin
         state   <= ST_ADDR;
         bit_cnt <= '0;
         drive   <= 1'b0;
      end else if (stop_det) begin
         state <= ST_IDLE;
         drive <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR: begin
               if (scl_rise) begin
                  rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (byte_end) begin
                  if (rx_sh[BYTE_W-1:1] == DEV_ADDR) begin
                     state       <= ST_ADDR_ACK;
                     drive       <= 1'b1;
                     is_read     <= rx_sh[0];
                     ptr_pending <= ~rx_sh[0];
                  end else begin
                     state <= ST_WAIT;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (scl_fall) begin
                  bit_cnt <= '0;
                  if (is_read) begin
                     state <= ST_TX;
                     tx_sh <= rd_data;
                     drive <= ~rd_data[BYTE_W-1];
                  end else begin
                     state <= ST_RX;
                     drive <= 1'b0;
                  end
               end
            end
            ST_RX: begin
               if (scl_rise) begin
                  rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (byte_end) begin
                  state <= ST_RX_ACK;
                  drive <= 1'b1;
                  if (ptr_pending) begin
                     ptr         <= rx_sh[PTR_W-1:0];
                     ptr_pending <= 1'b0;
                  end else begin
                     ptr <= ptr + 1'b1;
                  end
               end
            end
            ST_RX_ACK: begin
               if (scl_fall) begin
                  state   <= ST_RX;
                  drive   <= 1'b0;
                  bit_cnt <= '0;
               end
            end
            ST_TX: begin
               if (scl_rise) begin
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (byte_end) begin
                  state <= ST_TX_ACK;
                  drive <= 1'b0;
                  ptr   <= ptr + 1'b1;
               end else if (scl_fall) begin
                  tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                  drive <= ~tx_sh[BYTE_W-2];
               end
            end
            ST_TX_ACK: begin
               if (scl_rise) begin
                  master_ack <= ~sda_s;
               end else if (scl_fall) begin
                  if (master_ack) begin
                     state   <= ST_TX;
                     bit_cnt <= '0;
                     tx_sh   <= rd_data;
                     drive   <= ~rd_data[BYTE_W-1];
                  end else begin
                     state <= ST_WAIT;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_pull_low = drive;

   AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_ADDR) && !sda_pull_low); // R2

   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE) && !sda_pull_low); // R2

   AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR_ACK) |-> (rx_sh[BYTE_W-1:1] == DEV_ADDR)); // R3

   AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT || state == ST_IDLE) |-> !sda_pull_low); // R4

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ptr == PTR_W'($past(ptr) + 1'b1)); // R6

   AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull_low != $past(sda_pull_low)) |-> $past(scl_fall || start_det || stop_det)); // R9

endmodule

// File: tb/i2c_regfile_slave_test.sv
module i2c_regfile_slave_test;

   localparam logic [6:0] ADDR_A = 7'h2A;
   localparam logic [6:0] ADDR_B = 7'h55;
   localparam int NREGS = 8;
   localparam int H     = 6;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   wire  drv_a;
   wire  drv_b;
   wire  sda_bus = sda_m & ~drv_a & ~drv_b;

   i2c_regfile_slave #(.DEV_ADDR(ADDR_A), .NUM_REGS(NREGS)) uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_pull_low(drv_a));

   i2c_regfile_slave #(.DEV_ADDR(ADDR_B), .NUM_REGS(NREGS)) uut_b (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_pull_low(drv_b));

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [7:0] model [2][NREGS];
   int mptr [2];
   int r9_viol = 0;
   logic prev_a = 1'b0, prev_b = 1'b0;

   // R9 monitor: pull outputs may only move while the clock line is low
   always @(negedge clk) begin
      if (rst_n) begin
         if (scl_m && ((drv_a != prev_a) || (drv_b != prev_b))) r9_viol++;
         prev_a = drv_a;
         prev_b = drv_b;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic hold();
      repeat (H) @(posedge clk);
      #2;
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hold();
      scl_m = 1'b1; hold();
      sda_m = 1'b0; hold();
      scl_m = 1'b0; hold();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hold();
      scl_m = 1'b1; hold();
      sda_m = 1'b1; hold();
   endtask

   task automatic wbit(input logic b);
      sda_m = b; hold();
      scl_m = 1'b1; hold();
      scl_m = 1'b0; hold();
   endtask

   task automatic rbit(output logic b);
      sda_m = 1'b1; hold();
      scl_m = 1'b1; hold();
      b = sda_bus;
      scl_m = 1'b0; hold();
   endtask

   task automatic wbyte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) wbit(d[i]);
      rbit(b);
      ack = ~b;
   endtask

   task automatic rbyte(output logic [7:0] d, input logic give_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         rbit(b);
         d[i] = b;
      end
      wbit(~give_ack);
   endtask

   function automatic logic [6:0] dev_addr(input int d);
      return (d == 0) ? ADDR_A : ADDR_B;
   endfunction

   // write n bytes starting at pointer p, values seed + 37*k
   task automatic write_burst(input int d, input logic [7:0] pbyte, input int n, input int seed);
      logic ack;
      logic [7:0] v;
      bus_start();
      wbyte({dev_addr(d), 1'b0}, ack);
      check("R3 write address ack", ack, 1'b1);
      wbyte(pbyte, ack);
      check("R5 pointer byte ack", ack, 1'b1);
      mptr[d] = pbyte % NREGS;
      for (int k = 0; k < n; k++) begin
         v = 8'((seed + 37 * k) & 8'hFF);
         wbyte(v, ack);
         check("R5 data byte ack", ack, 1'b1);
         model[d][mptr[d]] = v;
         mptr[d] = (mptr[d] + 1) % NREGS;
      end
      bus_stop();
   endtask

   // read n bytes; when p >= 0 the pointer is set first and a repeated START used
   task automatic read_burst(input int d, input int p, input int n);
      logic ack;
      logic [7:0] v;
      bus_start();
      if (p >= 0) begin
         wbyte({dev_addr(d), 1'b0}, ack);
         check("R3 address ack before pointer", ack, 1'b1);
         wbyte(8'(p), ack);
         check("R5 pointer ack", ack, 1'b1);
         mptr[d] = p % NREGS;
         bus_start();
      end
      wbyte({dev_addr(d), 1'b1}, ack);
      check("R3 read address ack", ack, 1'b1);
      for (int k = 0; k < n; k++) begin
         rbyte(v, k != n - 1);
         check("R7 read data", v, model[d][mptr[d]]);
         mptr[d] = (mptr[d] + 1) % NREGS;
      end
      bus_stop();
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      report();
   end

   initial begin
      logic ack;
      logic b;
      logic [7:0] v;
      int zeros;
      for (int d = 0; d < 2; d++) begin
         for (int i = 0; i < NREGS; i++) model[d][i] = 8'h00;
         mptr[d] = 0;
      end
      repeat (5) @(posedge clk);
      #2;
      check("R1 pull output in reset", {drv_a, drv_b}, 2'b00);
      rst_n = 1'b1;
      hold();
      check("R1 pull output after reset", {drv_a, drv_b}, 2'b00);

      // R1: all registers zero after reset
      read_burst(0, 0, NREGS);

      // R5 R6: burst with truncated pointer 0xF3 -> 3 and wrap over the end
      write_burst(0, 8'hF3, 9, 5);
      // R6 R7: pointer kept from previous transaction, no pointer byte
      read_burst(0, -1, 1);
      // R6: full readback from 0
      read_burst(0, 0, NREGS);
      // R7: read wraps from the last register to register 0
      read_burst(0, 6, 3);

      // R8: NACK then extra clocks must see a released line
      read_burst(0, 1, 1);
      zeros = 0;
      bus_start();
      wbyte({ADDR_A, 1'b1}, ack);
      check("R3 read address ack", ack, 1'b1);
      rbyte(v, 1'b0);
      check("R8 byte before NACK", v, model[0][mptr[0]]);
      mptr[0] = (mptr[0] + 1) % NREGS;
      for (int i = 0; i < 9; i++) begin
         rbit(b);
         if (!b) zeros++;
      end
      check("R8 line released after NACK", zeros, 0);
      bus_stop();
      read_burst(0, -1, 1);

      // R3 R4: address sweep with two targets on the bus
      for (int a = 0; a < 128; a++) begin
         bus_start();
         wbyte({7'(a), 1'b0}, ack);
         check("R3 R4 address sweep ack", ack, (a == ADDR_A || a == ADDR_B));
         bus_stop();
      end

      // R4: unaddressed transaction stays silent and writes nothing
      bus_start();
      wbyte({7'h11, 1'b0}, ack);
      check("R4 mismatch address nack", ack, 1'b0);
      wbyte(8'h00, ack);
      check("R4 mismatch pointer byte nack", ack, 1'b0);
      wbyte(8'hAA, ack);
      check("R4 mismatch data byte nack", ack, 1'b0);
      bus_stop();
      read_burst(0, 0, NREGS);

      // R5: single-byte writes to every register of the second target
      for (int i = 0; i < NREGS; i++) write_burst(1, 8'(i), 1, 8'hC0 + i);
      read_burst(1, 0, NREGS);
      read_burst(0, 0, NREGS);

      // R2: STOP in the middle of a data byte discards it
      bus_start();
      wbyte({ADDR_A, 1'b0}, ack);
      check("R3 address ack", ack, 1'b1);
      wbyte(8'h05, ack);
      check("R5 pointer ack", ack, 1'b1);
      mptr[0] = 5;
      for (int i = 0; i < 4; i++) wbit(1'b1);
      bus_stop();
      read_burst(0, 5, 1);
      check("R2 aborted byte not stored", model[0][5], 8'((5 + 37 * 2) & 8'hFF));

      // R2: START in the middle of an address restarts reception
      bus_start();
      wbit(1'b1); wbit(1'b0); wbit(1'b1);
      bus_start();
      wbyte({ADDR_A, 1'b1}, ack);
      check("R2 address after restart acked", ack, 1'b1);
      rbyte(v, 1'b0);
      check("R2 read after restart", v, model[0][mptr[0]]);
      mptr[0] = (mptr[0] + 1) % NREGS;
      bus_stop();

      check("R9 pull changes only while clock low", r9_viol, 0);
      report();
   end

endmodule